// File: doc/BRIEF.md
# Priority-Reserved Read Request Queue

This block tracks read requests at the downstream side of an interconnect port. Requests arrive on a valid/ready channel that carries an ID, an address, a regular QoS value and a separate 4-bit arbitration QoS value. The arbitration value places each request in a class (high, medium or low). A slot count is reserved for high-class requests only, and a second count for medium-or-high requests. Because of this, low-class traffic can never fill the tracker and block urgent reads. The arbitration value is read combinationally while the request is stalled, so an upstream agent can raise it to promote a waiting request. The promotion lasts only until the request is admitted.

Each admitted entry keeps its regular QoS value. The entries waiting to go out are offered downstream one at a time, highest regular QoS first and oldest first among equals. A later high-QoS entry can therefore overtake an earlier promoted one. An issued entry still occupies its slot until a release pulse names that slot index. Only then can the slot be used again.

Top module: `prq_queue`

## Requirements
- R1: The arbitration QoS value sets the class. A value at or above UPPER_TH (default 12) is high. A value at or above LOWER_TH (default 6) but below UPPER_TH is medium. Any lower value is low.
- R2: `req_ready` is high exactly when occupancy is below the limit for the class. The limits are DEPTH for high, DEPTH-RSV_HI for medium and DEPTH-RSV_HI-RSV_MED for low. With the defaults DEPTH=8, RSV_HI=1, RSV_MED=2 these are 8, 7 and 5.
- R3: Admission uses the current arbitration QoS value during a stall. Raising it while `req_valid` is held makes `req_ready` rise in the same cycle once the new class limit allows it.
- R4: An admitted request goes into the lowest-numbered free slot. That slot keeps the request's ID, address and regular QoS.
- R5: `iss_valid` is high when at least one admitted entry has not been issued. The entry offered is the one with the highest stored regular QoS, and the oldest admission wins a tie. The arbitration QoS plays no part in this order.
- R6: On an `iss_valid`/`iss_ready` handshake, the offered entry leaves the set of candidates. It still counts toward occupancy.
- R7: A `rel_valid` pulse naming a slot that has been issued frees that slot and lowers occupancy by one. A pulse naming a free slot or a slot not yet issued has no effect.
- R8: An admit and a release in the same cycle both take effect, and occupancy is unchanged.
- R9: After reset every slot is free. `iss_valid` is low and `req_ready` is high for every class.
- R10: An entry admitted in a cycle cannot be offered on the issue port before the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request admitted this cycle if valid |
| req_id | input | ID_W | Request ID |
| req_addr | input | ADDR_W | Request address |
| req_qos | input | QOS_W | Regular QoS, used for issue order |
| req_arb_qos | input | 4 | Arbitration QoS, used for admission class |
| iss_valid | output | 1 | An entry is offered downstream |
| iss_ready | input | 1 | Downstream takes the offered entry |
| iss_id | output | ID_W | ID of the offered entry |
| iss_addr | output | ADDR_W | Address of the offered entry |
| iss_slot | output | SLOT_W | Slot index of the offered entry |
| rel_valid | input | 1 | Release pulse |
| rel_slot | input | SLOT_W | Slot index to release |

## Verification
The hardest state to reach is a promoted request crossing a class boundary exactly at the limit while a release lands in the same cycle. Reaching it needs the tracker held at a precise occupancy with downstream stalled. The bench first fills the tracker with low-class requests while `iss_ready` is held low, until `req_ready` drops. It then switches the arbitration value across each threshold on a stalled request, and issues and releases chosen slots to land on the boundary occupancy. A long mixed phase follows. In that phase random classes, random regular QoS, random release targets (including slots that are free or not yet issued) and random downstream stalls are each compared against a behavioural model every cycle.

// File: rtl/prq_pkg.sv
package prq_pkg;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'd0,
        CLS_MED  = 2'd1,
        CLS_HIGH = 2'd2
    } prq_cls_e;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_WAIT = 2'd1,
        SL_OUT  = 2'd2
    } prq_slot_e;

endpackage

// File: rtl/prq_classify.sv
module prq_classify
    import prq_pkg::*;
#(
    parameter int UPPER_TH = 12,
    parameter int LOWER_TH = 6
) (
    input  logic [3:0] arb_qos,
    output prq_cls_e   cls
);
    always_comb begin
        if (int'(arb_qos) >= UPPER_TH)      cls = CLS_HIGH;
        else if (int'(arb_qos) >= LOWER_TH) cls = CLS_MED;
        else                                cls = CLS_LOW;
    end
endmodule

// File: rtl/prq_first_free.sv
module prq_first_free #(
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  free_vec,
    output logic              any,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any = 1'b1;
                idx = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/prq_issue_pick.sv
module prq_issue_pick #(
    parameter int DEPTH  = 8,
    parameter int QOS_W  = 4,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][QOS_W-1:0] qos,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    output logic                        any,
    output logic [SLOT_W-1:0]           idx
);
    logic [DEPTH-1:0] win;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_win
        always_comb begin
            win[gi] = cand[gi];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != gi && cand[j]) begin
                    if (!((qos[gi] > qos[j]) ||
                          (qos[gi] == qos[j] && older[gi][j]))) begin
                        win[gi] = 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        any = |win;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (win[i]) idx = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/prq_queue.sv
module prq_queue
    import prq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int ID_W     = 4,
    parameter int ADDR_W   = 16,
    parameter int QOS_W    = 4,
    parameter int RSV_HI   = 1,
    parameter int RSV_MED  = 2,
    parameter int UPPER_TH = 12,
    parameter int LOWER_TH = 6,
    localparam int SLOT_W  = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [QOS_W-1:0]  req_qos,
    input  logic [3:0]        req_arb_qos,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [ID_W-1:0]   iss_id,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [SLOT_W-1:0] iss_slot,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot
);
    localparam int LIM_HI  = DEPTH;
    localparam int LIM_MED = DEPTH - RSV_HI;
    localparam int LIM_LOW = DEPTH - RSV_HI - RSV_MED;

    typedef struct packed {
        prq_slot_e [DEPTH-1:0]              st;
        logic [DEPTH-1:0][ID_W-1:0]         id;
        logic [DEPTH-1:0][ADDR_W-1:0]       addr;
        logic [DEPTH-1:0][QOS_W-1:0]        qos;
        logic [DEPTH-1:0][DEPTH-1:0]        older;
        logic [CNT_W-1:0]                   occ;
    } state_t;

    state_t q, d;

    prq_cls_e         cls;
    logic [CNT_W-1:0] limit;
    logic [DEPTH-1:0] free_vec, wait_vec;
    logic             free_any, pick_any;
    logic [SLOT_W-1:0] free_idx, pick_idx;
    logic             admit, issue, rel_hit;

    prq_classify #(.UPPER_TH(UPPER_TH), .LOWER_TH(LOWER_TH)) u_cls (
        .arb_qos (req_arb_qos),
        .cls     (cls)
    );

    for (genvar gs = 0; gs < DEPTH; gs++) begin : g_vec
        assign free_vec[gs] = (q.st[gs] == SL_FREE);
        assign wait_vec[gs] = (q.st[gs] == SL_WAIT);
    end

    prq_first_free #(.DEPTH(DEPTH)) u_free (
        .free_vec (free_vec),
        .any      (free_any),
        .idx      (free_idx)
    );

    prq_issue_pick #(.DEPTH(DEPTH), .QOS_W(QOS_W)) u_pick (
        .cand  (wait_vec),
        .qos   (q.qos),
        .older (q.older),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb begin
        unique case (cls)
            CLS_HIGH: limit = CNT_W'(LIM_HI);
            CLS_MED:  limit = CNT_W'(LIM_MED);
            default:  limit = CNT_W'(LIM_LOW);
        endcase
    end

    assign req_ready = (q.occ < limit) && free_any;
    assign iss_valid = pick_any;
    assign iss_slot  = pick_idx;
    assign iss_id    = q.id[pick_idx];
    assign iss_addr  = q.addr[pick_idx];

    always_comb begin
        d       = q;
        admit   = req_valid && req_ready;
        issue   = iss_valid && iss_ready;
        rel_hit = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            if (rel_valid && rel_slot == SLOT_W'(i) && q.st[i] == SL_OUT) begin
                d.st[i] = SL_FREE;
                rel_hit = 1'b1;
            end
        end

        if (issue) d.st[pick_idx] = SL_OUT;

        if (admit) begin
            d.st[free_idx]   = SL_WAIT;
            d.id[free_idx]   = req_id;
            d.addr[free_idx] = req_addr;
            d.qos[free_idx]  = req_qos;
            for (int j = 0; j < DEPTH; j++) begin
                d.older[j][free_idx] = (q.st[j] != SL_FREE);
                d.older[free_idx][j] = 1'b0;
            end
        end

        d.occ = q.occ + CNT_W'(admit) - CNT_W'(rel_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [DEPTH-1:0] busy_chk;
    for (genvar gb = 0; gb < DEPTH; gb++) begin : g_busy
        assign busy_chk[gb] = (q.st[gb] != SL_FREE);
    end

    // R2
    low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (admit && cls == CLS_LOW) |-> ($countones(busy_chk) < LIM_LOW));

    // R2
    med_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (admit && cls == CLS_MED) |-> ($countones(busy_chk) < LIM_MED));

    // R6
    issued_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (q.st[$past(iss_slot)] == SL_OUT));

    // R7
    release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && q.st[rel_slot] == SL_OUT) |=> (q.st[$past(rel_slot)] == SL_FREE));

    // R8
    occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.occ == CNT_W'($countones(busy_chk)));

    // R10
    fresh_not_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !(iss_valid && iss_slot == free_idx));

endmodule

// File: tb/sim_prq_queue.sv
module sim_prq_queue;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [3:0]  req_id = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_qos = '0, req_arb_qos = '0;
    logic        iss_valid, iss_ready = 1'b0;
    logic [3:0]  iss_id;
    logic [15:0] iss_addr;
    logic [2:0]  iss_slot;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_slot = '0;

    int total = 0, bad = 0;
    bit done = 0;

    int mst[DEPTH];
    int mid[DEPTH];
    int maddr[DEPTH];
    int mqos[DEPTH];
    int mstamp[DEPTH];
    int stamp = 0;
    bit last_acc;
    int last_pick;

    always #5 clk = ~clk;

    prq_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_addr(req_addr),
        .req_qos(req_qos), .req_arb_qos(req_arb_qos),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_id(iss_id), .iss_addr(iss_addr), .iss_slot(iss_slot),
        .rel_valid(rel_valid), .rel_slot(rel_slot)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occ_now();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) if (mst[i] != 0) c++;
        return c;
    endfunction

    // R1: class limit from the arbitration value
    function automatic int lim_of(input int a);
        if (a >= 12) return 8;
        if (a >= 6)  return 7;
        return 5;
    endfunction

    function automatic int pick_now();
        int b = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (mst[i] == 1) begin
                if (b < 0 || mqos[i] > mqos[b] ||
                    (mqos[i] == mqos[b] && mstamp[i] < mstamp[b])) b = i;
            end
        end
        return b;
    endfunction

    // one cycle: inputs already driven at negedge
    task automatic step();
        int e_rdy, b, ff;
        #1;
        e_rdy = (occ_now() < lim_of(int'(req_arb_qos))) ? 1 : 0;
        b = pick_now();
        chk(int'(req_ready) == e_rdy, "R2 ready", int'(req_ready), e_rdy);
        chk(int'(iss_valid) == (b >= 0 ? 1 : 0), "R5 iss_valid", int'(iss_valid), b >= 0);
        if (b >= 0) begin
            chk(int'(iss_slot) == b, "R5 iss_slot", int'(iss_slot), b);
            chk(int'(iss_id) == mid[b], "R4 iss_id", int'(iss_id), mid[b]);
            chk(int'(iss_addr) == maddr[b], "R4 iss_addr", int'(iss_addr), maddr[b]);
        end
        last_acc = req_valid && e_rdy == 1;
        last_pick = b;
        ff = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (mst[i] == 0) ff = i;
        @(posedge clk);
        if (rel_valid && mst[rel_slot] == 2) mst[rel_slot] = 0;
        if (b >= 0 && iss_ready) mst[b] = 2;
        if (last_acc) begin
            mst[ff] = 1; mid[ff] = int'(req_id); maddr[ff] = int'(req_addr);
            mqos[ff] = int'(req_qos); mstamp[ff] = stamp; stamp++;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        req_valid = 0; iss_ready = 0; rel_valid = 0;
    endtask

    task automatic push(input int arb, input int qos, input int id);
        req_valid = 1; req_arb_qos = 4'(arb); req_qos = 4'(qos);
        req_id = 4'(id); req_addr = 16'(id * 257 + 3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) mst[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9
        chk(req_ready == 1, "R9 ready after reset", req_ready, 1);
        chk(iss_valid == 0, "R9 iss_valid after reset", iss_valid, 0);
        @(negedge clk);

        // R10: first admission is not offered in its own cycle
        push(0, 3, 1);
        #1;
        chk(iss_valid == 0, "R10 same-cycle offer", iss_valid, 0);
        step();
        n = 1;
        // R2: low class fills to 5
        while (last_acc && n < 10) begin push(0, 3, n + 1); step(); n += last_acc; end
        chk(occ_now() == 5, "R2 low limit", occ_now(), 5);
        // R1: medium boundary
        push(5, 3, 9); #1; chk(req_ready == 0, "R1 arb 5 is low", req_ready, 0);
        push(6, 3, 9); #1; chk(req_ready == 1, "R1 arb 6 is medium", req_ready, 1);
        step(); step();
        chk(occ_now() == 7, "R2 medium limit", occ_now(), 7);
        push(11, 3, 10); #1; chk(req_ready == 0, "R1 arb 11 is medium", req_ready, 0);
        // R3: promotion during stall
        push(12, 9, 10); #1; chk(req_ready == 1, "R3 promoted ready", req_ready, 1);
        step();
        push(15, 9, 11); step();
        chk(last_acc == 0, "R2 full rejects high", last_acc, 0);
        idle_in();

        // R7: release of waiting slot has no effect
        rel_valid = 1; rel_slot = 0; step(); rel_valid = 0;
        chk(occ_now() == 8, "R7 waiting release ignored", occ_now(), 8);
        // R5/R6: issue entries, higher qos first
        iss_ready = 1; step();
        chk(last_pick == 7, "R5 highest qos first", last_pick, 7);
        iss_ready = 1; step(); iss_ready = 0;
        chk(last_pick == 0, "R5 oldest on tie", last_pick, 0);
        push(15, 1, 12); #1;
        chk(req_ready == 0, "R6 issued still occupies", req_ready, 0);
        // R8: release one, then admit and release together
        idle_in(); rel_valid = 1; rel_slot = 7; step();
        push(12, 1, 12); rel_valid = 1; rel_slot = 0; step();
        idle_in();
        chk(occ_now() == 7, "R8 admit and release together", occ_now(), 7);
        push(6, 1, 13); #1;
        chk(req_ready == 0, "R8 medium blocked at 7", req_ready, 0);
        idle_in();

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            req_valid = ($urandom % 3) != 0;
            req_arb_qos = 4'($urandom); req_qos = 4'($urandom % 4);
            req_id = 4'($urandom); req_addr = 16'($urandom);
            iss_ready = ($urandom % 2) == 0;
            rel_valid = ($urandom % 3) == 0;
            rel_slot = 3'($urandom);
            step();
        end
        idle_in();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule